// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block reads one 16-bit word from a three-wire serial EEPROM. The device has a chip select, a shift clock, a serial data input and a serial data output. A host places a word address on `addr_i` and pulses `start_i` for one cycle while the block is idle.

The block first holds chip select low for one half-period, then raises it. It then shifts out an 11-bit command field, most significant bit first. The field is two leading zeros, a start bit of 1, the read opcode `10`, and the 6-bit address. The block returns data out to 0 for one low half-period. It then gives 16 shift-clock pulses and samples the device's data line at the end of each high phase. The bits are assembled most significant bit first. After the last bit, chip select falls, `done_o` pulses for one cycle, and the word stays on `rdata_o`.

The shift-clock half-period is a parameter, counted in system clocks. Only reads are issued. No write, erase or whole-device burst command is sent.

Top module: `mw_eeprom_rd`

## Requirements
- R1: After reset, `ee_cs_o`, `ee_sk_o`, `ee_do_o`, `busy_o`, `done_o` and `rdata_o` are all 0.
- R2: A start strobe taken while idle raises `busy_o` in the next cycle. `busy_o` stays high until the cycle in which `done_o` is high. `done_o` is a one-cycle pulse, and `busy_o` is low in that cycle.
- R3: For one half-period after an accepted start, `ee_cs_o` stays low. It is then high through the command and data phases, and it is low again in the `done_o` cycle.
- R4: The command is 11 bits sent MSB first. In order: 0, 0, 1 (start bit), 1, 0 (read opcode), then the six address bits MSB first. As a value this is (6 << 6) | address.
- R5: Each command bit is placed on `ee_do_o` during a low shift-clock half-period and held unchanged through the high half-period that follows.
- R6: After the command, one low half-period follows with `ee_do_o` at 0. Then 16 clock pulses follow, with `ee_do_o` held at 0. `ee_di_i` is sampled at the end of each high half-period, and the first bit sampled becomes bit 15 of the result.
- R7: `rdata_o` holds the assembled word from the `done_o` cycle until the next accepted start.
- R8: Every shift-clock half-period lasts `HALF_CYC` system clocks. A full read takes 57 × `HALF_CYC` cycles from the start edge to `done_o`.
- R9: A start strobe while `busy_o` is high is ignored. The address and command in flight are unchanged, and no second read follows.
- R10: `ee_sk_o` is high only while `ee_cs_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to read a word |
| addr_i | input | ADDR_W | Word address, sampled on an accepted start |
| busy_o | output | 1 | High while a read is in progress |
| done_o | output | 1 | One-cycle pulse when the word is ready |
| rdata_o | output | DATA_W | Last word read |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM shift clock |
| ee_do_o | output | 1 | Serial data to the EEPROM |
| ee_di_i | input | 1 | Serial data from the EEPROM |

## Verification
A behavioural EEPROM in the bench decodes the command from the wires and answers with a word computed from the address. The addresses used are 0 and 63, a mixed pattern, and a run of random addresses. Addresses 0 and 63 show whether the address bits follow the opcode in the right order and whether the start bit is present. The random addresses, each with its own data word, catch bit reversal or a shift that is off by one in both directions. A strobe with a different address in the middle of a read separates a design that ignores strobes while busy from one that reloads the address or queues a second read. Wire-level monitors measure each high half-period and catch data changes while the clock is high.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_LO,
        ST_CS_HI,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_GAP,
        ST_DAT_HI,
        ST_DAT_LO
    } mwr_state_e;

    // start bit followed by the read opcode
    localparam logic [2:0] RD_HEADER = 3'b110;
    // zero bits sent ahead of the start bit
    localparam int LEAD_ZEROS = 2;

endpackage

// File: rtl/mwr_tick.sv
module mwr_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8
    cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/mwr_shreg.sv
module mwr_shreg #(
    parameter int W         = 16,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_d, sh_q, shifted;

    generate
        if (MSB_FIRST) begin : g_msb
            assign shifted = {sh_q[W-2:0], sin};
        end else begin : g_lsb
            assign shifted = {sin, sh_q[W-1:1]};
        end
    endgenerate

    always_comb begin
        sh_d = sh_q;
        if (clr)        sh_d = '0;
        else if (shift) sh_d = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q;

    // R7
    hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !shift) |=> $stable(sh_q));

endmodule

// File: rtl/mw_eeprom_rd.sv
module mw_eeprom_rd #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_do_o,
    input  logic              ee_di_i
);
    import mwr_pkg::*;

    localparam int CMD_W = ADDR_W + 3 + LEAD_ZEROS;
    localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        mwr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] cmd;
        logic             cs;
        logic             sk;
        logic             sdo;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tick, rx_clr, rx_shift;

    mwr_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctl_q.st != ST_IDLE),
        .tick (tick)
    );

    mwr_shreg #(.W(DATA_W), .MSB_FIRST(1'b1)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rx_clr),
        .shift(rx_shift),
        .sin  (ee_di_i),
        .q    (rdata_o)
    );

    assign rx_clr   = (ctl_q.st == ST_IDLE) && start_i;
    assign rx_shift = (ctl_q.st == ST_DAT_HI) && tick;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st  = ST_CS_LO;
                    ctl_d.cmd = {{LEAD_ZEROS{1'b0}}, RD_HEADER, addr_i};
                end
            end
            ST_CS_LO:  if (tick) ctl_d.st = ST_CS_HI;
            ST_CS_HI: begin
                if (tick) begin
                    ctl_d.st  = ST_CMD_LO;
                    ctl_d.cnt = CMD_LAST;
                end
            end
            ST_CMD_LO: if (tick) ctl_d.st = ST_CMD_HI;
            ST_CMD_HI: begin
                if (tick) begin
                    if (ctl_q.cnt == '0) ctl_d.st = ST_GAP;
                    else begin
                        ctl_d.st  = ST_CMD_LO;
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    ctl_d.st  = ST_DAT_HI;
                    ctl_d.cnt = DAT_LAST;
                end
            end
            ST_DAT_HI: if (tick) ctl_d.st = ST_DAT_LO;
            ST_DAT_LO: begin
                if (tick) begin
                    if (ctl_q.cnt == '0) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st  = ST_DAT_HI;
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        ctl_d.cs  = (ctl_d.st != ST_IDLE) && (ctl_d.st != ST_CS_LO);
        ctl_d.sk  = (ctl_d.st == ST_CMD_HI) || (ctl_d.st == ST_DAT_HI);
        ctl_d.sdo = ((ctl_d.st == ST_CMD_LO) || (ctl_d.st == ST_CMD_HI))
                    ? ctl_d.cmd[ctl_d.cnt] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o  = (ctl_q.st != ST_IDLE);
    assign done_o  = ctl_q.done;
    assign ee_cs_o = ctl_q.cs;
    assign ee_sk_o = ctl_q.sk;
    assign ee_do_o = ctl_q.sdo;

    // R10
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk_o |-> ee_cs_o);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R5
    do_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_do_o));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(ctl_q.cmd));

    // R3
    cs_low_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ee_cs_o);

    // R7
    rdata_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(rdata_o));

endmodule

// File: tb/sim_mw_eeprom_rd.sv
module sim_mw_eeprom_rd;
    localparam int HALF  = 3;
    localparam int TOTAL = 57 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  addr = '0;
    logic        busy, done, cs, sk, mosi;
    logic        miso = 1'b0;
    logic [15:0] rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mw_eeprom_rd #(.ADDR_W(6), .DATA_W(16), .HALF_CYC(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
        .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .ee_cs_o(cs), .ee_sk_o(sk), .ee_do_o(mosi), .ee_di_i(miso)
    );

    function automatic logic [15:0] pat(input logic [5:0] a);
        return {a, a[3:0], ~a} ^ 16'h9C35;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural EEPROM
    int          m_n = 0;
    bit          m_act = 1'b0;
    logic [10:0] m_cmd = '0;
    logic [15:0] m_word = '0;
    int          m_ptr = 15;
    int          m_do_bad = 0;

    always @(posedge cs) begin
        m_n = 0; m_act = 1'b0; m_cmd = '0;
    end

    always @(posedge sk) begin
        if (cs) begin
            if (!m_act) begin
                m_cmd = {m_cmd[9:0], mosi};
                m_n++;
                if (m_n == 11) begin
                    m_act  = 1'b1;
                    m_word = pat(m_cmd[5:0]);
                    m_ptr  = 15;
                end
            end else begin
                if (mosi !== 1'b0) m_do_bad++;
                if (m_ptr >= 0) miso = m_word[m_ptr];
                m_ptr--;
            end
        end
    end

    // wire monitors
    int   hi_run = 0, hi_bad = 0, hold_bad = 0, skcs_bad = 0;
    logic p_sk = 1'b0, p_do = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sk && p_sk && (mosi !== p_do)) hold_bad++;
            if (sk && !cs) skcs_bad++;
            if (sk) hi_run++;
            else if (hi_run > 0) begin
                if (hi_run != HALF) hi_bad++;
                hi_run = 0;
            end
        end
        p_sk = sk; p_do = mosi;
    end

    task automatic do_read(input logic [5:0] a, input bit poke, input logic [5:0] other);
        int k;
        bit cs_lo_ok, cs_hi_ok, busy_ok;
        @(negedge clk);
        addr  = a;
        start = 1'b1;
        @(posedge clk);
        k = 0;
        cs_lo_ok = 1'b1; cs_hi_ok = 1'b1; busy_ok = 1'b1;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (k < HALF && cs !== 1'b0) cs_lo_ok = 1'b0;
            if (k == HALF && cs !== 1'b1) cs_hi_ok = 1'b0;
            if (poke && k == 20) begin
                start = 1'b1;
                addr  = other;
            end
            if (done === 1'b1 || k > TOTAL + 10) break;
            if (busy !== 1'b1) busy_ok = 1'b0;
            @(posedge clk);
            k++;
        end
        chk(k == TOTAL, "R8 read length", k, TOTAL);
        chk(busy === 1'b0 && cs === 1'b0, "R2/R3 idle at done", {busy, cs}, 0);
        chk(busy_ok, "R2 busy held", 0, 1);
        chk(cs_lo_ok && cs_hi_ok, "R3 cs low then high", {cs_lo_ok, cs_hi_ok}, 3);
        chk(rdata === pat(a), "R6 data word", rdata, pat(a));
        chk(m_cmd === {5'b00110, a}, "R4 command field", m_cmd, {5'b00110, a});
        @(negedge clk);
        chk(done === 1'b0, "R2 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(rdata === pat(a), "R7 data held", rdata, pat(a));
        chk(busy === 1'b0, "R9 no queued read", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd77));
        repeat (3) @(negedge clk);
        chk({cs, sk, mosi, busy, done} === 5'b0, "R1 reset outputs", {cs, sk, mosi, busy, done}, 0);
        chk(rdata === 16'h0, "R1 reset data", rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read(6'd0, 1'b0, 6'd0);
        do_read(6'd63, 1'b0, 6'd0);
        do_read(6'h15, 1'b0, 6'd0);
        do_read(6'h0A, 1'b1, 6'h35);   // R9 strobe during busy
        for (int i = 0; i < 12; i++) begin
            do_read(6'($urandom % 64), 1'b0, 6'd0);
        end
        chk(hold_bad == 0, "R5 data held while clock high", hold_bad, 0);
        chk(hi_bad == 0, "R8 high half-period", hi_bad, 0);
        chk(skcs_bad == 0, "R10 clock only with select", skcs_bad, 0);
        chk(m_do_bad == 0, "R6 data out zero in read phase", m_do_bad, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule